// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block decides the ordering of two unsigned words: whether A is larger than B, smaller than B, or the same. It is built from 4-bit slices. Each slice orders its own pair of 4-bit fields and also takes a three-wire ordering result from the slice below it. The wider word is split into fields. The highest field that differs settles the answer. When a slice's own fields match, it passes along whatever the slice beneath it reported.

The top level splits a WIDTH-bit pair into WIDTH/4 fields and chains one slice per field, from least to most significant. The bottom slice receives a fixed "equal so far" seed. The result is read from the top slice. The block is purely combinational and has no clock, no reset and no handshake. The operands are plain level inputs and the three flags follow them directly. The stream-style valid/ready convention does not apply here, because nothing is stored and nothing can be held back.

Top module: `magcmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i` as unsigned integers.
- R2: `lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned integers.
- R3: `eq_o` is 1 exactly when `a_i` equals `b_i`. This includes the all-zero pair and the all-ones pair.
- R4: Exactly one of `gt_o`, `lt_o`, `eq_o` is 1 for every operand pair. The flags read as a 3-bit code {gt, lt, eq}: 3'b100 means greater, 3'b010 means less, 3'b001 means equal.
- R5: When the 4-bit fields of a slice differ, that slice's own ordering sets its output, and the result from less significant fields has no effect. For example, A=8'h30 and B=8'h2F gives 3'b100.
- R6: When the 4-bit fields of a slice match, the slice forwards unchanged the ordering it receives from the slice below. The bottom slice receives the seed {gt=0, lt=0, eq=1}.
- R7: WIDTH must be a multiple of 4. The chain holds WIDTH/4 slices, and the field in bits [4k+3:4k] is handled by slice k. Slice 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i  | input     | WIDTH | Operand A, unsigned |
| b_i  | input     | WIDTH | Operand B, unsigned |
| gt_o | output    | 1     | A is greater than B |
| lt_o | output    | 1     | A is less than B |
| eq_o | output    | 1     | A equals B |

## Verification
The bench targets several kinds of pairs:
- **Fields that disagree in direction.** The upper field favours one operand and the lower field favours the other, as in 30/2F and 0F/F0. A design that let a lower slice override a differing upper slice would invert the answer on these pairs.
- **Operands one step apart across a field boundary.** A chain that dropped or swapped the cascade wires would call 45 and 46 equal or reverse them.
- **All-zero and all-ones pairs.** A wrongly chosen seed would show up here as no flag high, or as two flags high.

Every 8-bit pair is applied and checked against an integer reference. This catches a slip in a single bit position of the local ordering logic. A 16-bit chain is also driven with random pairs to cover longer cascades.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  // Ordering code carried between slices.
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } order_t;

  // Seed for the least significant slice: "equal so far".
  localparam order_t ORDER_SEED = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

  localparam int unsigned FIELD_W = 4;

endpackage

// File: rtl/magcmp_local.sv
// Orders one field pair by a priority scan from the MSB down.
module magcmp_local
  import magcmp_pkg::*;
#(
  parameter int unsigned W = FIELD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output order_t       rel_o
);

  // same_above[i] : all bits strictly above position i-1 match
  logic [W:0]   same_above;
  logic [W-1:0] win;
  logic [W-1:0] lose;

  assign same_above[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign same_above[i] = same_above[i+1] & (a_i[i] ~^ b_i[i]);
    assign win[i]        = same_above[i+1] & a_i[i] & ~b_i[i];
    assign lose[i]       = same_above[i+1] & ~a_i[i] & b_i[i];
  end

  assign rel_o.gt = |win;
  assign rel_o.lt = |lose;
  assign rel_o.eq = same_above[0];

  // R4: the local ordering is always a single choice
  always_comb begin
    assert_local_onehot_R4: assert ($onehot({rel_o.gt, rel_o.lt, rel_o.eq}))
      else $error("local ordering not one-hot");
  end

endmodule

// File: rtl/magcmp_slice.sv
// One cascadable slice: local ordering folded with the ordering from below.
module magcmp_slice
  import magcmp_pkg::*;
#(
  parameter int unsigned W = FIELD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  order_t       casc_i,
  output order_t       res_o
);

  order_t rel;

  magcmp_local #(.W(W)) i_local (
    .a_i  (a_i),
    .b_i  (b_i),
    .rel_o(rel)
  );

  always_comb begin
    res_o.gt = rel.gt | (rel.eq & casc_i.gt);
    res_o.lt = rel.lt | (rel.eq & casc_i.lt);
    res_o.eq = rel.eq & casc_i.eq;
  end

  always_comb begin
    // R5: a differing field decides on its own
    if (a_i > b_i) begin
      assert_field_wins_R5: assert (res_o.gt && !res_o.lt && !res_o.eq)
        else $error("slice ignored its own greater field");
    end
    if (a_i < b_i) begin
      assert_field_loses_R5: assert (res_o.lt && !res_o.gt && !res_o.eq)
        else $error("slice ignored its own smaller field");
    end
    // R6: matching fields pass the lower result through
    if (a_i == b_i) begin
      assert_pass_through_R6: assert (res_o == casc_i)
        else $error("slice altered the cascade on equal fields");
    end
    // R4: a legal cascade code stays legal
    if ($onehot({casc_i.gt, casc_i.lt, casc_i.eq})) begin
      assert_slice_onehot_R4: assert ($onehot({res_o.gt, res_o.lt, res_o.eq}))
        else $error("slice output not one-hot");
    end
  end

endmodule

// File: rtl/magcmp_chain.sv
// WIDTH-bit unsigned comparator built from a chain of 4-bit slices.
module magcmp_chain
  import magcmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);

  localparam int unsigned NSLICE = WIDTH / FIELD_W;

  // R7: WIDTH must split into whole fields
  initial begin
    assert_width_multiple_R7: assert (WIDTH % FIELD_W == 0 && NSLICE > 0)
      else $error("WIDTH must be a positive multiple of the field width");
  end

  // link[k] feeds slice k; link[NSLICE] is the final result
  order_t link [NSLICE+1];

  assign link[0] = ORDER_SEED;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    magcmp_slice #(.W(FIELD_W)) i_slice (
      .a_i   (a_i[k*FIELD_W +: FIELD_W]),
      .b_i   (b_i[k*FIELD_W +: FIELD_W]),
      .casc_i(link[k]),
      .res_o (link[k+1])
    );
  end

  assign gt_o = link[NSLICE].gt;
  assign lt_o = link[NSLICE].lt;
  assign eq_o = link[NSLICE].eq;

  always_comb begin
    assert_final_onehot_R4: assert ($onehot({gt_o, lt_o, eq_o}))
      else $error("final flags not one-hot");
    assert_final_equal_R3: assert (eq_o == (a_i == b_i))
      else $error("equal flag disagrees with operands");
    assert_final_greater_R1: assert (gt_o == (a_i > b_i))
      else $error("greater flag disagrees with operands");
    assert_final_less_R2: assert (lt_o == (a_i < b_i))
      else $error("less flag disagrees with operands");
  end

endmodule

// File: tb/test_magcmp_chain.sv
module test_magcmp_chain;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WIDE_W     = 16;
  localparam int  N_RANDOM   = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] a8 = '0, b8 = '0;
  logic gt8, lt8, eq8;
  logic [WIDE_W-1:0] aw = '0, bw = '0;
  logic gtw, ltw, eqw;

  magcmp_chain #(.WIDTH(8)) i_magcmp_chain (
    .a_i(a8), .b_i(b8), .gt_o(gt8), .lt_o(lt8), .eq_o(eq8)
  );

  magcmp_chain #(.WIDTH(WIDE_W)) i_magcmp_chain_wide (
    .a_i(aw), .b_i(bw), .gt_o(gtw), .lt_o(ltw), .eq_o(eqw)
  );

  // Code {gt, lt, eq}: 100 greater, 010 less, 001 equal.
  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [2:0] code;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 3'b001, 4'd3},  // R3 all zero
    '{8'hFF, 8'hFF, 3'b001, 4'd3},  // R3 all ones
    '{8'h80, 8'h7F, 3'b100, 4'd1},  // R1 top bit decides
    '{8'h7F, 8'h80, 3'b010, 4'd2},  // R2
    '{8'h30, 8'h2F, 3'b100, 4'd5},  // R5 upper wins over lower
    '{8'h2F, 8'h30, 3'b010, 4'd5},  // R5
    '{8'hF0, 8'h0F, 3'b100, 4'd5},  // R5
    '{8'h0F, 8'hF0, 3'b010, 4'd5},  // R5
    '{8'h45, 8'h46, 3'b010, 4'd6},  // R6 lower slice decides
    '{8'h46, 8'h45, 3'b100, 4'd6},  // R6
    '{8'h5A, 8'h5A, 3'b001, 4'd6},  // R6 seed reaches top
    '{8'h01, 8'h00, 3'b100, 4'd7}   // R7 field 0 is bits 3..0
  };

  function automatic logic [2:0] ref_code(input longint unsigned a, input longint unsigned b);
    if (a > b)      return 3'b100;
    else if (a < b) return 3'b010;
    else            return 3'b001;
  endfunction

  function automatic int ref_req(input logic [2:0] code);
    if (code == 3'b100)      return 1;  // R1
    else if (code == 3'b010) return 2;  // R2
    else                     return 3;  // R3
  endfunction

  task automatic check8(input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] code, input int req);
    logic [2:0] got;
    @(posedge clk);
    a8 = a;
    b8 = b;
    @(negedge clk);
    got = {gt8, lt8, eq8};
    checks++;
    if (got !== code) begin
      fails++;
      $display("FAIL R%0d a=%h b=%h actual=%b expected=%b", req, a, b, got, code);
    end
    checks++;
    if ($countones(got) != 1) begin  // R4
      fails++;
      $display("FAIL R4 a=%h b=%h actual=%b expected=one-hot", a, b, got);
    end
  endtask

  task automatic check_wide(input logic [WIDE_W-1:0] a, input logic [WIDE_W-1:0] b);
    logic [2:0] got, code;
    @(posedge clk);
    aw = a;
    bw = b;
    @(negedge clk);
    got  = {gtw, ltw, eqw};
    code = ref_code(longint'(a), longint'(b));
    checks++;
    if (got !== code) begin
      fails++;
      $display("FAIL R%0d wide a=%h b=%h actual=%b expected=%b",
               ref_req(code), a, b, got, code);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle inputs (all zero) must read as equal: R3, R4
    @(negedge clk);
    checks++;
    if ({gt8, lt8, eq8} !== 3'b001) begin
      fails++;
      $display("FAIL R3 idle actual=%b expected=001", {gt8, lt8, eq8});
    end

    // Table walk
    for (int i = 0; i < NV; i++)
      check8(VECS[i].a, VECS[i].b, VECS[i].code, int'(VECS[i].req));

    // Exhaustive 8-bit sweep: R1 R2 R3 R4
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        check8(8'(a), 8'(b), ref_code(longint'(a), longint'(b)),
               ref_req(ref_code(longint'(a), longint'(b))));

    // Wide chain: corners, then R5 across four slices, then random
    check_wide('0, '0);
    check_wide('1, '1);
    check_wide('1, '0);
    check_wide('0, '1);
    check_wide(16'h1000, 16'h0FFF);
    check_wide(16'h0FFF, 16'h1000);
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [WIDE_W-1:0] ra, rb;
      ra = WIDE_W'($urandom);
      rb = (n % 4 == 0) ? ra : WIDE_W'($urandom);
      check_wide(ra, rb);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule